// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small bank of hardware tokens that two agents, a left port and a right port, use to take turns on shared resources. Each token is separate from any data storage. A port asks for a token by writing a 0 to it and gives the token up, or withdraws an unanswered request, by writing a 1. A port finds out whether it holds a token by reading it. The read returns all zeros only to the holder.

The bank remembers a request that the non-holding side made while the token was taken. When the holder lets go, the waiting side receives the token on that same clock edge, so it never has to ask again. Both sides share one clock. Every access is a single-cycle strobe, and read data comes back from a register one cycle later.

Top module: `sem_token_bank`

## Requirements
- R1: The bank has NUM_SEM tokens (default 8). The low log2(NUM_SEM) address bits select the token, and every higher address bit has no effect on which token is touched.
- R2: A port takes part only while its token select is 1 and its memory enable is 0. With both at 1, that port's write strobe leaves every token unchanged and its read strobe leaves its read register unchanged.
- R3: A write uses only the single write-data bit. A value of 0 means "request this token" and a value of 1 means "release it, or cancel my request".
- R4: A read strobe at a clock edge loads that port's read register with every bit equal to that port's view of the addressed token. The view is 0 if this port holds the token, and 1 if the token is free or held by the other port. The register keeps its value until the next accepted read.
- R5: After reset every token is free, no request is pending, and both read registers are all ones.
- R6: A request for a free token, with no write to that token from the other side in the same cycle, makes the requester the holder at that edge.
- R7: A request from the non-holding side while the token is held changes neither view. The request is remembered, and the token passes to that side at the edge where the holder writes 1.
- R8: A release written by the non-holding side cancels its pending request, so a later release by the holder leaves the token free.
- R9: When both sides request a free token in the same cycle, the left port becomes the holder and the right request stays pending.
- R10: No token is ever held by both sides at once.
- R11: A read returns the token state from before the edge at which it is sampled. A write by the other port in that same cycle does not alter the value being read.
- R12: Only the holder changes a held token. The holder writing 0 again and the other side writing 1 without a pending request both leave the holder in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| lt_sel | input | 1 | Left token select |
| lt_mem_en | input | 1 | Left memory enable; must be 0 for token access |
| lt_addr | input | ADDR_W | Left address; low bits pick the token |
| lt_wr | input | 1 | Left write strobe |
| lt_rd | input | 1 | Left read strobe |
| lt_wbit | input | 1 | Left write value (0 request, 1 release) |
| lt_rdat | output | RD_W | Left read register, every bit the left view |
| rt_sel | input | 1 | Right token select |
| rt_mem_en | input | 1 | Right memory enable; must be 0 for token access |
| rt_addr | input | ADDR_W | Right address; low bits pick the token |
| rt_wr | input | 1 | Right write strobe |
| rt_rd | input | 1 | Right read strobe |
| rt_wbit | input | 1 | Right write value (0 request, 1 release) |
| rt_rdat | output | RD_W | Right read register, every bit the right view |

## Verification
Two pairs of events can meet on one token in a single cycle. One pair is both ports requesting the same free token. The other is one port reading while the other port's release hands the token to the reader. The bench drives both ports at the same falling edge to create each case. For the tie, it expects the left port to win and the right request to be served later. For the read collision, it expects the pre-edge value (1) in the reader's register, followed by 0 on the next read. A long pseudo-random walk then mixes requests, releases, blocked accesses and random upper address bits on both ports at once. Each result is compared with an arithmetic model of holder and pending state.

// File: rtl/sem_token_pkg.sv
package sem_token_pkg;

   typedef enum logic [1:0] {
      HOLD_NONE = 2'd0,
      HOLD_LT   = 2'd1,
      HOLD_RT   = 2'd2
   } holder_e;

endpackage

// File: rtl/sem_port_decode.sv
// Turns one port's strobes into a per-token write vector and a read enable.
module sem_port_decode #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               sel,
   input  logic               mem_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic               wr,
   input  logic               rd,
   output logic [NUM_SEM-1:0] wr_hit,
   output logic               rd_go
);

   logic acc;

   assign acc   = sel & ~mem_en;
   assign rd_go = acc & rd;

   always_comb begin
      for (int k = 0; k < NUM_SEM; k++) begin
         wr_hit[k] = acc & wr & (idx == IDX_W'(k));
      end
   end

endmodule

// File: rtl/sem_token_cell.sv
// One token: holder plus one pending-request flag per side.
module sem_token_cell
   import sem_token_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lt_wr,
   input  logic lt_bit,
   input  logic rt_wr,
   input  logic rt_bit,
   output logic lt_owns,
   output logic rt_owns
);

   holder_e holder_q, holder_d;
   logic    want_lt_q, want_rt_q;
   logic    want_lt_d, want_rt_d;
   logic    keep;

   always_comb begin
      want_lt_d = lt_wr ? ~lt_bit : want_lt_q;
      want_rt_d = rt_wr ? ~rt_bit : want_rt_q;
      keep = ((holder_q == HOLD_LT) && want_lt_d) ||
             ((holder_q == HOLD_RT) && want_rt_d);
      if (keep)
         holder_d = holder_q;
      else if (want_lt_d && want_rt_d)
         holder_d = (holder_q == HOLD_LT) ? HOLD_RT : HOLD_LT;
      else if (want_lt_d)
         holder_d = HOLD_LT;
      else if (want_rt_d)
         holder_d = HOLD_RT;
      else
         holder_d = HOLD_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holder_q  <= HOLD_NONE;
         want_lt_q <= 1'b0;
         want_rt_q <= 1'b0;
      end else begin
         holder_q  <= holder_d;
         want_lt_q <= want_lt_d;
         want_rt_q <= want_rt_d;
      end
   end

   assign lt_owns = (holder_q == HOLD_LT);
   assign rt_owns = (holder_q == HOLD_RT);

endmodule

// File: rtl/sem_view_reg.sv
// Captures one side's view of the addressed token on an accepted read.
module sem_view_reg #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM),
   parameter int RD_W    = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_go,
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] owns,
   output logic [RD_W-1:0]    rdat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdat <= '1;
      else if (rd_go)
         rdat <= {RD_W{~owns[idx]}};
   end

endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 16,
   parameter int RD_W    = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_sel,
   input  logic              lt_mem_en,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_wr,
   input  logic              lt_rd,
   input  logic              lt_wbit,
   output logic [RD_W-1:0]   lt_rdat,
   input  logic              rt_sel,
   input  logic              rt_mem_en,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_wr,
   input  logic              rt_rd,
   input  logic              rt_wbit,
   output logic [RD_W-1:0]   rt_rdat
);

   localparam int IDX_W = $clog2(NUM_SEM);

   generate
      if (NUM_SEM < 2 || (NUM_SEM & (NUM_SEM - 1)) != 0) begin : g_bad_count
         $error("NUM_SEM must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the token index width");
      end
      if (RD_W < 1) begin : g_bad_rd
         $error("RD_W must be at least 1");
      end
   endgenerate

   logic [NUM_SEM-1:0] hit_lt, hit_rt;
   logic [NUM_SEM-1:0] own_lt, own_rt;
   logic               go_lt, go_rt;
   logic               hi_unused;

   // Upper address bits play no part in token selection.
   assign hi_unused = ^{lt_addr[ADDR_W-1:IDX_W], rt_addr[ADDR_W-1:IDX_W]};

   sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_lt (
      .sel(lt_sel), .mem_en(lt_mem_en), .idx(lt_addr[IDX_W-1:0]),
      .wr(lt_wr), .rd(lt_rd), .wr_hit(hit_lt), .rd_go(go_lt)
   );

   sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_rt (
      .sel(rt_sel), .mem_en(rt_mem_en), .idx(rt_addr[IDX_W-1:0]),
      .wr(rt_wr), .rd(rt_rd), .wr_hit(hit_rt), .rd_go(go_rt)
   );

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
         sem_token_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .lt_wr(hit_lt[g]), .lt_bit(lt_wbit),
            .rt_wr(hit_rt[g]), .rt_bit(rt_wbit),
            .lt_owns(own_lt[g]), .rt_owns(own_rt[g])
         );
      end
   endgenerate

   sem_view_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .RD_W(RD_W)) u_view_lt (
      .clk(clk), .rst_n(rst_n), .rd_go(go_lt), .idx(lt_addr[IDX_W-1:0]),
      .owns(own_lt), .rdat(lt_rdat)
   );

   sem_view_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .RD_W(RD_W)) u_view_rt (
      .clk(clk), .rst_n(rst_n), .rd_go(go_rt), .idx(rt_addr[IDX_W-1:0]),
      .owns(own_rt), .rdat(rt_rdat)
   );

endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 16,
   parameter int RD_W    = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lt_sel,
   input logic              lt_mem_en,
   input logic [ADDR_W-1:0] lt_addr,
   input logic              lt_wr,
   input logic              lt_rd,
   input logic              lt_wbit,
   input logic [RD_W-1:0]   lt_rdat,
   input logic              rt_sel,
   input logic              rt_mem_en,
   input logic [ADDR_W-1:0] rt_addr,
   input logic              rt_wr,
   input logic              rt_rd,
   input logic              rt_wbit,
   input logic [RD_W-1:0]   rt_rdat,
   input logic [NUM_SEM-1:0] own_lt,
   input logic [NUM_SEM-1:0] own_rt
);

   localparam int IDX_W = $clog2(NUM_SEM);

   logic lt_acc, rt_acc, chk_unused;
   assign lt_acc = lt_sel & ~lt_mem_en;
   assign rt_acc = rt_sel & ~rt_mem_en;
   assign chk_unused = ^{lt_addr[ADDR_W-1:IDX_W], rt_addr[ADDR_W-1:IDX_W]};

   assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (own_lt & own_rt) == '0);

   assert_view_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_rdat == '0 || lt_rdat == '1) && (rt_rdat == '0 || rt_rdat == '1));

   assert_lt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(lt_acc && lt_rd) |=> $stable(lt_rdat));

   assert_rt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rt_acc && rt_rd) |=> $stable(rt_rdat));

   assert_blocked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_sel && lt_mem_en && !(rt_acc && rt_wr)) |=>
         ($stable(own_lt) && $stable(own_rt)));

   assert_reset_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lt_rdat == '1 && rt_rdat == '1 && own_lt == '0 && own_rt == '0));

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_tok
         logic lw, rw;
         assign lw = lt_acc & lt_wr & (lt_addr[IDX_W-1:0] == IDX_W'(g));
         assign rw = rt_acc & rt_wr & (rt_addr[IDX_W-1:0] == IDX_W'(g));

         assert_free_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_lt[g] && !own_rt[g] && lw && !lt_wbit && !rw) |=> own_lt[g]);

         assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_lt[g] && !own_rt[g] && lw && !lt_wbit && rw && !rt_wbit) |=> own_lt[g]);

         assert_lt_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (own_lt[g] && !lw) |=> own_lt[g]);

         assert_rt_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (own_rt[g] && !rw) |=> own_rt[g]);
      end
   endgenerate

endmodule

bind sem_token_bank sem_token_bank_chk #(
   .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .RD_W(RD_W)
) u_chk (.*);

// File: tb/sim_sem_token_bank.sv
module sim_sem_token_bank;

   localparam int NS = 8;
   localparam int AW = 16;
   localparam int RW = 18;
   localparam int IW = 3;
   localparam logic [RW-1:0] ZERO = '0;
   localparam logic [RW-1:0] ONES = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lt_sel = 0, lt_mem_en = 0, lt_wr = 0, lt_rd = 0, lt_wbit = 0;
   logic rt_sel = 0, rt_mem_en = 0, rt_wr = 0, rt_rd = 0, rt_wbit = 0;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic [RW-1:0] lt_rdat, rt_rdat;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] lf = 16'hACE1;

   // model: holder 0 free, 1 left, 2 right; pending wishes per side
   int mh[NS];
   bit mwl[NS];
   bit mwr[NS];

   always #10 clk = ~clk;

   sem_token_bank u0 (.*);

   task automatic rnd(output logic [15:0] r);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r = lf;
   endtask

   task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_update(input bit lw, input int li, input bit lv,
                               input bit rw, input int ri, input bit rv);
      for (int k = 0; k < NS; k++) begin
         bit wl, wr2, keep;
         wl  = (lw && li == k) ? !lv : mwl[k];
         wr2 = (rw && ri == k) ? !rv : mwr[k];
         keep = (mh[k] == 1 && wl) || (mh[k] == 2 && wr2);
         if (!keep) begin
            if (wl && wr2) mh[k] = (mh[k] == 1) ? 2 : 1;
            else if (wl)   mh[k] = 1;
            else if (wr2)  mh[k] = 2;
            else           mh[k] = 0;
         end
         mwl[k] = wl;
         mwr[k] = wr2;
      end
   endtask

   // One access cycle on both ports; returns read registers after the edge.
   task automatic cyc(input logic ls, input logic lm, input logic lw, input logic lv,
                      input logic lr, input int li,
                      input logic rs, input logic rm, input logic rw, input logic rv,
                      input logic rr, input int ri,
                      output logic [RW-1:0] ra, output logic [RW-1:0] rb);
      logic [15:0] h;
      @(negedge clk);
      rnd(h);
      lt_sel = ls; lt_mem_en = lm; lt_wr = lw; lt_wbit = lv; lt_rd = lr;
      lt_addr = AW'({h[12:0], IW'(li)});
      rnd(h);
      rt_sel = rs; rt_mem_en = rm; rt_wr = rw; rt_wbit = rv; rt_rd = rr;
      rt_addr = AW'({h[12:0], IW'(ri)});
      @(negedge clk);
      ra = lt_rdat;
      rb = rt_rdat;
      lt_sel = 0; lt_mem_en = 0; lt_wr = 0; lt_rd = 0; lt_wbit = 0;
      rt_sel = 0; rt_mem_en = 0; rt_wr = 0; rt_rd = 0; rt_wbit = 0;
      model_update(ls && !lm && lw, li, lv, rs && !rm && rw, ri, rv);
   endtask

   task automatic wr_l(input int i, input logic v);
      logic [RW-1:0] a, b;
      cyc(1, 0, 1, v, 0, i, 0, 0, 0, 0, 0, 0, a, b);
   endtask

   task automatic wr_r(input int i, input logic v);
      logic [RW-1:0] a, b;
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, v, 0, i, a, b);
   endtask

   task automatic expect_views(input int i, input logic el, input logic er, input string tag);
      logic [RW-1:0] a, b;
      cyc(1, 0, 0, 0, 1, i, 1, 0, 0, 0, 1, i, a, b);
      check({tag, " left"}, a, {RW{el}});
      check({tag, " right"}, b, {RW{er}});
   endtask

   task automatic expect_model(input int i);
      expect_views(i, !(mh[i] == 1), !(mh[i] == 2), "R10 walk");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [RW-1:0] a, b;
      logic [15:0] r;
      for (int k = 0; k < NS; k++) begin mh[k] = 0; mwl[k] = 0; mwr[k] = 0; end
      repeat (3) @(negedge clk);
      check("R5 reset left rdat", lt_rdat, ONES);
      check("R5 reset right rdat", rt_rdat, ONES);
      rst_n = 1'b1;
      for (int k = 0; k < NS; k++) expect_views(k, 1, 1, "R5 free");

      // R6 / R1: grant on free token, neighbours untouched
      wr_l(3, 0);
      expect_views(3, 0, 1, "R6 grant");
      expect_views(2, 1, 1, "R1 neighbour");
      expect_views(4, 1, 1, "R1 neighbour");

      // R7: pending request, transfer on release
      wr_r(3, 0);
      expect_views(3, 0, 1, "R7 pending");
      wr_l(3, 1);
      expect_views(3, 1, 0, "R7 transfer");

      // R12: holder re-request and non-holder release leave holder
      wr_r(3, 0);
      expect_views(3, 1, 0, "R12 re-request");
      wr_l(3, 1);
      expect_views(3, 1, 0, "R12 foreign release");
      wr_r(3, 1);
      expect_views(3, 1, 1, "R3 release frees");

      // R8: cancelled pending request
      wr_l(5, 0);
      wr_r(5, 0);
      wr_r(5, 1);
      wr_l(5, 1);
      expect_views(5, 1, 1, "R8 cancel");

      // R9: same-cycle tie
      cyc(1, 0, 1, 0, 0, 6, 1, 0, 1, 0, 0, 6, a, b);
      expect_views(6, 0, 1, "R9 tie");
      wr_l(6, 1);
      expect_views(6, 1, 0, "R9 right served");
      wr_r(6, 1);
      expect_views(6, 1, 1, "R9 free");

      // R2: blocked write and blocked read
      cyc(1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, a, b);
      expect_views(1, 1, 1, "R2 blocked write");
      cyc(1, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0, 0, a, b);
      check("R4 read free", a, ONES);
      wr_l(0, 0);
      cyc(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, a, b);
      check("R2 blocked read", a, ONES);
      expect_views(0, 0, 1, "R4 holder view");
      wr_l(0, 1);

      // R11: read collides with the other side's handing release
      wr_r(2, 0);
      wr_l(2, 0);
      cyc(1, 0, 0, 0, 1, 2, 1, 0, 1, 1, 0, 2, a, b);
      check("R11 pre-edge view", a, ONES);
      expect_views(2, 0, 1, "R11 after handoff");
      wr_l(2, 1);

      // random walk on both ports against the model
      for (int n = 0; n < 1500; n++) begin
         logic lw, lv, rw, rv, lb, rb2;
         int li, ri;
         rnd(r);
         lw = (r[1:0] == 2'd1) || (r[1:0] == 2'd2);
         lv = (r[1:0] == 2'd2);
         li = int'(r[4:2]);
         rw = (r[6:5] == 2'd1) || (r[6:5] == 2'd2);
         rv = (r[6:5] == 2'd2);
         ri = int'(r[9:7]);
         lb = (r[12:10] == 3'd0);
         rb2 = (r[15:13] == 3'd0);
         cyc(lw | lb, lb, lw, lv, 0, li, rw | rb2, rb2, rw, rv, 0, ri, a, b);
         expect_model(li);
         expect_model(ri);
      end
      for (int k = 0; k < NS; k++) expect_model(k);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule